// File: doc/BRIEF.md
# BCD Calendar Timekeeper

This block keeps wall-clock time and calendar date in eight byte-wide registers, all in packed BCD. The registers hold hundredths of a second, seconds, minutes, hours, day of week, date, month and a two-digit year. A single-cycle enable pulse at 100 Hz advances the count by one hundredth. Carries ripple through the whole calendar within that same clock edge. Month length is derived from the month register, and February gains a 29th day in every year divisible by four.

The hours register can count in either of two formats, chosen by its top bit. In 24-hour form it runs 00 to 23. In 12-hour form it runs 12, 01 … 11 and carries an afternoon flag. The day register also holds two control bits. One halts timekeeping, and the other is a stored reset-ignore flag for the surrounding logic. Software sets the time through a parallel load port, which writes all eight registers in one cycle. A 64-bit snapshot output shows the full set at all times.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the snapshot reads 64'h0001_0131_0000_0000: year 00, month 01, date 01, day register 8'h31 (halt bit 5 set, reset-ignore bit 4 set, weekday 1), hours 00 in 24-hour mode, and zero minutes, seconds and hundredths. Byte k of the snapshot (bits 8k+7:8k) is register k, in the order hundredths, seconds, minutes, hours, day, date, month, year.
- R2: Each tick while running adds one hundredth. Hundredths wrap 99→00 and carry into seconds. Seconds and minutes each wrap 59→00 and carry onward.
- R3: A cycle with tick low and no load leaves every register unchanged.
- R4: While bit 5 of the day register is 1, ticks change nothing.
- R5: With hours bit 7 clear (24-hour mode), hours bits 5:0 run 00..23. The step from 23 to 00 advances the date.
- R6: With hours bit 7 set (12-hour mode), hours bits 4:0 run 12, 01 … 11, and bit 5 is the PM flag. Going from 11 to 12 toggles PM. Going from 11 PM to 12 AM advances the date, while 12→01 leaves the flag alone.
- R7: After the last date of the month (30 for months 04, 06, 09, 11; 31 for 01, 03, 05, 07, 08, 10, 12), the date returns to 01 and the month advances.
- R8: February ends on 29 when the BCD year is divisible by four and on 28 otherwise.
- R9: Day of week (bits 2:0) advances with each date change and wraps 7→1.
- R10: Month wraps 12→01 and advances the year. Year wraps 99→00.
- R11: When load is high, the next snapshot holds the loaded set, even if a tick arrives in the same cycle.
- R12: Loads force fixed bits to zero: bit 7 of seconds and minutes, bit 6 of hours, bits 7, 6 and 3 of the day, bits 7:6 of the date, and bits 7:5 of the month. Day bits 5 and 4 are stored exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle 100 Hz advance enable |
| loadEn | input | 1 | Writes all eight registers from loadData |
| loadData | input | 64 | Register set to load, byte k is register k |
| snapshot | output | 64 | Current register set, byte k is register k |

## Verification
The bench aims at carry chains that cross every field in one tick: 23:59:59.99 on the last day of February in both leap and common years, at the end of 30- and 31-day months, and at 31 December 99. A design with a wrong month-length table or leap rule would land on a nonexistent date or skip one. A missing weekday wrap would show weekday 0 or 8. Twelve-hour mode is driven through 11→12 and 12→01 in both halves of the day. Putting the flag toggle on the wrong step would swap AM and PM or change the date at noon. A load collides with a tick to expose any partial increment of the loaded set. Out-of-range bits are written to reveal registers that keep them.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 8;
  localparam int SNAP_W   = REG_W * NUM_REGS;

  // Byte order of the register set; the load and snapshot ports depend on it
  localparam int IDX_HUND  = 0;
  localparam int IDX_SEC   = 1;
  localparam int IDX_MIN   = 2;
  localparam int IDX_HOUR  = 3;
  localparam int IDX_DAY   = 4;
  localparam int IDX_DATE  = 5;
  localparam int IDX_MONTH = 6;
  localparam int IDX_YEAR  = 7;

  // Bits that survive a load, one byte per register
  localparam logic [SNAP_W-1:0] LOAD_MASK =
    {8'hFF, 8'h1F, 8'h3F, 8'h37, 8'hBF, 8'h7F, 8'h7F, 8'hFF};

  // Bit positions inside the hours and day registers
  localparam int HOUR_MODE12_BIT = 7;
  localparam int HOUR_PM_BIT     = 5;
  localparam int DAY_HALT_BIT    = 5;
  localparam int DAY_RSTIGN_BIT  = 4;

  localparam logic [SNAP_W-1:0] RESET_SET = 64'h0001_0131_0000_0000;

  typedef struct packed {
    logic loadAll;
    logic incHund;
    logic incSec;
    logic incMin;
    logic incHour;
    logic incDay;
    logic incMonth;
    logic incYear;
  } strobe_t;

  typedef struct packed {
    logic hundMax;
    logic secMax;
    logic minMax;
    logic hourWrap;
    logic dateMax;
    logic monthMax;
    logic halted;
  } status_t;

  function automatic logic [REG_W-1:0] bcdInc(input logic [REG_W-1:0] v);
    logic [REG_W-1:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction
endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    loadEn,
  input  status_t status,
  output strobe_t stb
);
  logic runTick;

  // Load wins over a same-cycle tick; the halt bit gates ticks
  assign runTick = tick & ~loadEn & ~status.halted;

  always_comb begin
    stb          = '0;
    stb.loadAll  = loadEn;
    stb.incHund  = runTick;
    stb.incSec   = stb.incHund  & status.hundMax;
    stb.incMin   = stb.incSec   & status.secMax;
    stb.incHour  = stb.incMin   & status.minMax;
    stb.incDay   = stb.incHour  & status.hourWrap;
    stb.incMonth = stb.incDay   & status.dateMax;
    stb.incYear  = stb.incMonth & status.monthMax;
  end

  // R4: halted clock issues no advance
  a_r4_halt_blocks: assert property (@(posedge clk) disable iff (!rstN)
    status.halted |-> !stb.incHund);

  // R11: load suppresses every increment strobe
  a_r11_load_priority: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |-> !(stb.incHund || stb.incSec || stb.incDay));
endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [SNAP_W-1:0] loadData,
  output logic [SNAP_W-1:0] snapshot,
  output status_t           status
);
  logic [REG_W-1:0] hundR, secR, minR, hourR, dayR, dateR, monthR, yearR;
  logic [SNAP_W-1:0] loadMasked;
  logic [REG_W-1:0] ldByte [NUM_REGS];
  logic [REG_W-1:0] monthLast;
  logic             leapYear;
  logic [REG_W-1:0] hour24Inc, hour12Inc, hourNext, dayNext;
  logic             mode12, pmFlag;

  assign loadMasked = loadData & LOAD_MASK;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_ldSplit
    assign ldByte[k] = loadMasked[k*REG_W +: REG_W];
  end

  assign snapshot = {yearR, monthR, dateR, dayR, hourR, minR, secR, hundR};

  // Divisible by four on a BCD year: even tens need ones 0/4/8, odd tens 2/6
  always_comb begin
    if (yearR[4]) leapYear = (yearR[3:0] == 4'd2) || (yearR[3:0] == 4'd6);
    else          leapYear = (yearR[3:0] == 4'd0) || (yearR[3:0] == 4'd4) ||
                             (yearR[3:0] == 4'd8);
  end

  always_comb begin
    unique case (monthR)
      8'h02:                      monthLast = leapYear ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: monthLast = 8'h30;
      default:                    monthLast = 8'h31;
    endcase
  end

  assign mode12 = hourR[HOUR_MODE12_BIT];
  assign pmFlag = hourR[HOUR_PM_BIT];

  always_comb begin
    hour24Inc = bcdInc({2'b00, hourR[5:0]});
    hour12Inc = bcdInc({3'b000, hourR[4:0]});
    if (mode12) begin
      if (hourR[4:0] == 5'h12)      hourNext = {1'b1, 1'b0, pmFlag, 5'h01};
      else if (hourR[4:0] == 5'h11) hourNext = {1'b1, 1'b0, ~pmFlag, 5'h12};
      else                          hourNext = {1'b1, 1'b0, pmFlag, hour12Inc[4:0]};
    end else begin
      if (hourR[5:0] == 6'h23)      hourNext = 8'h00;
      else                          hourNext = {2'b00, hour24Inc[5:0]};
    end
  end

  always_comb begin
    dayNext      = dayR;
    dayNext[2:0] = (dayR[2:0] == 3'd7) ? 3'd1 : dayR[2:0] + 3'd1;
  end

  always_comb begin
    status          = '0;
    status.hundMax  = (hundR == 8'h99);
    status.secMax   = (secR == 8'h59);
    status.minMax   = (minR == 8'h59);
    status.hourWrap = mode12 ? (pmFlag && hourR[4:0] == 5'h11) : (hourR[5:0] == 6'h23);
    status.dateMax  = (dateR == monthLast);
    status.monthMax = (monthR == 8'h12);
    status.halted   = dayR[DAY_HALT_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {yearR, monthR, dateR, dayR, hourR, minR, secR, hundR} <= RESET_SET;
    end else if (stb.loadAll) begin
      hundR  <= ldByte[IDX_HUND];
      secR   <= ldByte[IDX_SEC];
      minR   <= ldByte[IDX_MIN];
      hourR  <= ldByte[IDX_HOUR];
      dayR   <= ldByte[IDX_DAY];
      dateR  <= ldByte[IDX_DATE];
      monthR <= ldByte[IDX_MONTH];
      yearR  <= ldByte[IDX_YEAR];
    end else begin
      if (stb.incHund)  hundR  <= status.hundMax  ? 8'h00 : bcdInc(hundR);
      if (stb.incSec)   secR   <= status.secMax   ? 8'h00 : bcdInc(secR);
      if (stb.incMin)   minR   <= status.minMax   ? 8'h00 : bcdInc(minR);
      if (stb.incHour)  hourR  <= hourNext;
      if (stb.incDay) begin
        dayR  <= dayNext;
        dateR <= status.dateMax ? 8'h01 : bcdInc(dateR);
      end
      if (stb.incMonth) monthR <= status.monthMax ? 8'h01 : bcdInc(monthR);
      if (stb.incYear)  yearR  <= (yearR == 8'h99) ? 8'h00 : bcdInc(yearR);
    end
  end

  // R3: no strobe, no change
  a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (stb == '0) |=> $stable(snapshot));

  // R2: hundredths wrap to zero on carry
  a_r2_hund_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incHund && !stb.loadAll && hundR == 8'h99) |=> hundR == 8'h00);

  // R6: PM flag flips on 11 -> 12 only
  a_r6_pm_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incHour && !stb.loadAll && mode12 && hourR[4:0] == 5'h11)
      |=> (hourR[HOUR_PM_BIT] != $past(hourR[HOUR_PM_BIT])));

  // R9: weekday never leaves 1..7 once advanced
  a_r9_dow_range: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incDay && !stb.loadAll) |=> (dayR[2:0] != 3'd0));

  // R12: fixed-zero bits stay zero
  a_r12_zero_bits: assert property (@(posedge clk) disable iff (!rstN)
    !secR[7] && !minR[7] && !hourR[6] && !dateR[7] && monthR[7:5] == 3'b000);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              loadEn,
  input  logic [SNAP_W-1:0] loadData,
  output logic [SNAP_W-1:0] snapshot
);
  strobe_t stb;
  status_t status;

  rtc_cal_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .loadEn (loadEn),
    .status (status),
    .stb    (stb)
  );

  rtc_cal_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .loadData (loadData),
    .snapshot (snapshot),
    .status   (status)
  );

  // R11: loaded hundredths and seconds appear the next cycle
  a_r11_load_visible: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (snapshot[7:0] == $past(loadData[7:0])) &&
               (snapshot[15:8] == ($past(loadData[15:8]) & 8'h7F)));
endmodule

// File: tb/tb_rtc_calendar.sv
module tb_rtc_calendar;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        loadEn = 1'b0;
  logic [63:0] loadData = '0;
  logic [63:0] snapshot;

  int checks = 0;
  int fails  = 0;

  // behavioural model state
  int mHund, mSec, mMin, mHr, mDow, mDate, mMonth, mYear;
  bit mMode12, mPm, mHalt, mRstIgn;

  always #2 clk = ~clk;

  rtc_calendar dut (
    .clk(clk), .rstN(rstN), .tick(tick), .loadEn(loadEn),
    .loadData(loadData), .snapshot(snapshot)
  );

  function automatic int fromBcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] toBcd(input int n);
    logic [7:0] r;
    r[7:4] = 4'(n / 10);
    r[3:0] = 4'(n % 10);
    return r;
  endfunction

  function automatic int monthDays(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [63:0] expected();
    logic [7:0] hb, db;
    logic [7:0] hv;
    hv = toBcd(mHr);
    if (mMode12) hb = {1'b1, 1'b0, mPm, hv[4:0]};
    else         hb = {2'b00, hv[5:0]};
    db = {2'b00, mHalt, mRstIgn, 1'b0, 3'(mDow)};
    return {toBcd(mYear), toBcd(mMonth), toBcd(mDate), db, hb,
            toBcd(mMin), toBcd(mSec), toBcd(mHund)};
  endfunction

  task automatic modelReset();
    mHund = 0; mSec = 0; mMin = 0; mHr = 0; mDow = 1; mDate = 1;
    mMonth = 1; mYear = 0; mMode12 = 0; mPm = 0; mHalt = 1; mRstIgn = 1;
  endtask

  task automatic dayAdvance();
    mDow = (mDow == 7) ? 1 : mDow + 1;
    mDate++;
    if (mDate > monthDays(mMonth, mYear)) begin
      mDate = 1;
      mMonth++;
      if (mMonth == 13) begin
        mMonth = 1;
        mYear = (mYear + 1) % 100;
      end
    end
  endtask

  task automatic hourAdvance();
    if (!mMode12) begin
      mHr++;
      if (mHr == 24) begin mHr = 0; dayAdvance(); end
    end else if (mHr == 11) begin
      mHr = 12;
      mPm = !mPm;
      if (!mPm) dayAdvance();
    end else if (mHr == 12) mHr = 1;
    else mHr++;
  endtask

  task automatic modelStep(input bit tk, input bit ld, input logic [63:0] d);
    if (ld) begin
      mHund = fromBcd(d[7:0]);
      mSec  = fromBcd({1'b0, d[14:8]});
      mMin  = fromBcd({1'b0, d[22:16]});
      mMode12 = d[31];
      if (d[31]) begin mPm = d[29]; mHr = fromBcd({3'b000, d[28:24]}); end
      else begin mPm = 0; mHr = fromBcd({2'b00, d[29:24]}); end
      mHalt   = d[37];
      mRstIgn = d[36];
      mDow    = int'(d[34:32]);
      mDate   = fromBcd({2'b00, d[45:40]});
      mMonth  = fromBcd({3'b000, d[52:48]});
      mYear   = fromBcd(d[63:56]);
    end else if (tk && !mHalt) begin
      mHund++;
      if (mHund == 100) begin
        mHund = 0; mSec++;
        if (mSec == 60) begin
          mSec = 0; mMin++;
          if (mMin == 60) begin mMin = 0; hourAdvance(); end
        end
      end
    end
  endtask

  task automatic checkNow(input string req);
    logic [63:0] e;
    e = expected();
    checks++;
    if (snapshot !== e) begin
      fails++;
      $display("FAIL %s: snapshot=%h expected=%h", req, snapshot, e);
    end
  endtask

  // one clock: drive at negedge, model after posedge, compare at next negedge
  task automatic cyc(input bit tk, input bit ld, input logic [63:0] d, input string req);
    tick = tk; loadEn = ld; loadData = d;
    @(posedge clk);
    modelStep(tk, ld, d);
    @(negedge clk);
    tick = 1'b0; loadEn = 1'b0;
    checkNow(req);
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, '0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkNow("R1 reset state");
    rstN = 1'b1;

    // R4: reset leaves the clock halted; ticks do nothing
    run(5, "R4 halted after reset");

    // R11: load collides with tick; 24h 23:59:59.98, Feb 28 of leap year 24, weekday 7
    cyc(1'b1, 1'b1, 64'h24_02_28_17_23_59_59_98, "R11 load beats tick");
    // R3: no tick, nothing moves
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, '0, "R3 idle");
    run(1, "R2 hundredths step");
    run(1, "R8 leap Feb 28 to 29 and R9 weekday wrap");
    run(150, "R2 carry into seconds");

    // R8: common year Feb 28 -> Mar 1
    cyc(1'b0, 1'b1, 64'h23_02_28_03_23_59_59_99, "R11 load");
    run(1, "R8 common Feb");
    // leap Feb 29 -> Mar 1
    cyc(1'b0, 1'b1, 64'h28_02_29_05_23_59_59_99, "R11 load");
    run(1, "R8 leap Feb end");
    // R7: 30-day and 31-day months
    cyc(1'b0, 1'b1, 64'h25_04_30_02_23_59_59_99, "R11 load");
    run(1, "R7 April end");
    cyc(1'b0, 1'b1, 64'h25_01_31_02_23_59_59_99, "R7 load");
    run(1, "R7 January end");
    cyc(1'b0, 1'b1, 64'h25_09_29_02_23_59_59_99, "R7 load");
    run(1, "R7 September 29 to 30");
    // R10: year end and century wrap
    cyc(1'b0, 1'b1, 64'h99_12_31_06_23_59_59_99, "R10 load");
    run(1, "R10 year 99 to 00");
    // R5: 24h through the hour boundary
    cyc(1'b0, 1'b1, 64'h30_06_15_04_09_59_59_97, "R5 load");
    run(4, "R5 hour 09 to 10");
    cyc(1'b0, 1'b1, 64'h30_06_15_04_19_59_59_99, "R5 load");
    run(1, "R5 hour 19 to 20");

    // R6: 12h mode sequences
    cyc(1'b0, 1'b1, 64'h31_03_10_01_91_59_59_99, "R6 load 11 AM");
    run(1, "R6 11 AM to 12 PM");
    cyc(1'b0, 1'b1, 64'h31_03_10_01_B2_59_59_99, "R6 load 12 PM");
    run(1, "R6 12 PM to 01 PM");
    cyc(1'b0, 1'b1, 64'h31_03_31_07_B1_59_59_99, "R6 load 11 PM");
    run(1, "R6 11 PM to 12 AM next day");
    cyc(1'b0, 1'b1, 64'h31_03_10_01_92_59_59_99, "R6 load 12 AM");
    run(1, "R6 12 AM to 01 AM");
    cyc(1'b0, 1'b1, 64'h31_03_10_01_89_59_59_98, "R6 load 09 AM");
    run(2, "R6 09 AM to 10 AM");

    // R12: fixed-zero bits written as ones are dropped; control bits stored
    cyc(1'b0, 1'b1, 64'h12_E6_D5_C3_50_C5_D9_42, "R12 masked load");
    run(3, "R12 running after masked load");
    cyc(1'b0, 1'b1, 64'h12_06_15_23_10_45_59_42, "R12 halt bit stored");
    run(3, "R4 halt bit blocks ticks");

    // R2: long run through minute carries, then sparse ticks
    cyc(1'b0, 1'b1, 64'h20_11_30_07_23_58_59_00, "R2 load");
    run(6100, "R2 carries over minutes and midnight");
    for (int i = 0; i < 400; i++) cyc(1'($urandom % 2), 1'b0, '0, "R3 sparse ticks");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule